// File: doc/BRIEF.md
# Exception Entry Controller

The controller sits beside a processor pipeline and handles the single cycle in which an exception is taken. When the core raises a request with a numeric cause index, the controller works out where execution should resume after the handler. It bases this on whether the faulting instruction occupied a branch delay slot and on the class of the cause. It then saves the old status word and builds a new status word with supervisor privilege and with interrupts, the tick timer and both address translations disabled. Finally it presents the handler's vector address together with a one-cycle redirect strobe and a one-cycle translation-buffer flush strobe.

Causes fall into two classes. Tick-timer, external interrupt, system call and floating-point causes resume past the faulting point. Every other cause restarts the faulting instruction. A cause index that names no defined exception does not vector. It produces an error strobe and leaves every held register as it was. All outputs are registered, and all state is updated at the clock edge that accepts the request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is held, and immediately after it is released, every output is zero.
- R2: Outside a delay slot, a cause of 5 (tick), 8 (interrupt), 12 (system call) or 13 (floating point) sets the return address to `pc_next_i`.
- R3: Outside a delay slot, any other legal cause sets the return address to `pc_cur_i`.
- R4: In a delay slot, a cause in the class of R2 sets the return address to `pc_branch_i`. Any other legal cause sets it to `pc_cur_i` minus 4.
- R5: When an entry is accepted with `ds_flag_i` set, `ds_clr_o` pulses for one cycle and bit 13 of the new status word is set. Outside a delay slot, bit 13 is copied from `sr_i` and `ds_clr_o` stays low.
- R6: `esr_o` receives the value that `sr_i` had in the accepting cycle.
- R7: In the new status word, bit 0 is 1, bits 1, 2, 5 and 6 are 0, and all other bits except bit 13 are copied from `sr_i`.
- R8: A legal entry makes `redirect_o` high for exactly the cycle after the accepting edge. During that cycle `vec_pc_o` equals the cause index shifted left by 8.
- R9: A cause of 0, or a cause of 15 or above, pulses `cause_err_o` for one cycle. In that case there is no redirect and no flush, and the return address, the saved status, the status word and the vector keep their previous values.
- R10: `tlb_flush_o` pulses for one cycle with every legal entry. `xlate_off_o` goes high on the first legal entry and stays high until reset.
- R11: In a cycle after an edge with no request, all strobes are low and every held output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Exception request, accepted at each rising edge where it is high |
| exc_cause_i | input | 4 | Cause index |
| pc_cur_i | input | 32 | PC of the faulting instruction |
| pc_next_i | input | 32 | PC of the next sequential instruction |
| pc_branch_i | input | 32 | Target of the pending branch |
| ds_flag_i | input | 1 | Faulting instruction sits in a delay slot |
| sr_i | input | 32 | Current status word |
| redirect_o | output | 1 | One-cycle strobe: fetch from `vec_pc_o` |
| vec_pc_o | output | 32 | Handler vector address |
| epc_o | output | 32 | Exception return address |
| esr_o | output | 32 | Saved status word |
| sr_o | output | 32 | New status word |
| ds_clr_o | output | 1 | One-cycle strobe: clear the core's delay-slot flag |
| tlb_flush_o | output | 1 | One-cycle translation-buffer flush strobe |
| xlate_off_o | output | 1 | Address translation bypassed |
| cause_err_o | output | 1 | One-cycle strobe: illegal cause index |

## Verification
Two functions can overlap in time. A second request can arrive in the very cycle in which the strobes of the first entry are visible. Likewise, an illegal cause can follow a legal entry directly. The bench provokes both by holding the request high across consecutive edges with different causes, PCs and status words. It then judges that the redirect and flush strobes stay high for exactly as many cycles as there were legal requests, and that each cycle shows the values of its own request. For an illegal request in the second slot, the bench checks that the error strobe appears and that the held values of the preceding entry survive.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 4,
  parameter int N_CAUSES   = 15,
  parameter int TICK_CAUSE = 5,
  parameter int IRQ_CAUSE  = 8,
  parameter int SYS_CAUSE  = 12,
  parameter int FPE_CAUSE  = 13,
  parameter int VEC_SHIFT  = 8,
  parameter int SM_BIT     = 0,
  parameter int TEE_BIT    = 1,
  parameter int IEE_BIT    = 2,
  parameter int DME_BIT    = 5,
  parameter int IME_BIT    = 6,
  parameter int DSX_BIT    = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req_i,
  input  logic [CAUSE_W-1:0] exc_cause_i,
  input  logic [XLEN-1:0]    pc_cur_i,
  input  logic [XLEN-1:0]    pc_next_i,
  input  logic [XLEN-1:0]    pc_branch_i,
  input  logic               ds_flag_i,
  input  logic [XLEN-1:0]    sr_i,
  output logic               redirect_o,
  output logic [XLEN-1:0]    vec_pc_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    esr_o,
  output logic [XLEN-1:0]    sr_o,
  output logic               ds_clr_o,
  output logic               tlb_flush_o,
  output logic               xlate_off_o,
  output logic               cause_err_o
);

  localparam logic [XLEN-1:0] ONE      = XLEN'(1);
  localparam logic [XLEN-1:0] CLR_MASK = (ONE << TEE_BIT) | (ONE << IEE_BIT) |
                                         (ONE << DME_BIT) | (ONE << IME_BIT);
  localparam logic [XLEN-1:0] SM_MASK  = ONE << SM_BIT;
  localparam logic [XLEN-1:0] DSX_MASK = ONE << DSX_BIT;

  logic [31:0]     cause_ext;
  logic            legal, resume_cls, take, bad;
  logic [XLEN-1:0] ret_addr, sr_new, vec_new;

  assign cause_ext  = 32'(exc_cause_i);
  assign legal      = (cause_ext != 32'd0) && (cause_ext < 32'(N_CAUSES));
  assign resume_cls = (cause_ext == 32'(TICK_CAUSE)) || (cause_ext == 32'(IRQ_CAUSE)) ||
                      (cause_ext == 32'(SYS_CAUSE))  || (cause_ext == 32'(FPE_CAUSE));
  assign take       = exc_req_i & legal;
  assign bad        = exc_req_i & ~legal;

  assign ret_addr = ds_flag_i ? (resume_cls ? pc_branch_i : pc_cur_i - XLEN'(4))
                              : (resume_cls ? pc_next_i   : pc_cur_i);
  assign sr_new   = (sr_i & ~CLR_MASK) | SM_MASK | (ds_flag_i ? DSX_MASK : '0);
  assign vec_new  = XLEN'(exc_cause_i) << VEC_SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o  <= 1'b0;
      tlb_flush_o <= 1'b0;
      ds_clr_o    <= 1'b0;
      cause_err_o <= 1'b0;
      xlate_off_o <= 1'b0;
      vec_pc_o    <= '0;
      epc_o       <= '0;
      esr_o       <= '0;
      sr_o        <= '0;
    end else begin
      redirect_o  <= take;
      tlb_flush_o <= take;
      ds_clr_o    <= take & ds_flag_i;
      cause_err_o <= bad;
      if (take) begin
        xlate_off_o <= 1'b1;
        vec_pc_o    <= vec_new;
        epc_o       <= ret_addr;
        esr_o       <= sr_i;
        sr_o        <= sr_new;
      end
    end
  end

  // R5
  dsx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> sr_o[DSX_BIT] == ($past(ds_flag_i) | $past(sr_i[DSX_BIT])));
  // R5
  ds_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_clr_o |-> redirect_o && sr_o[DSX_BIT]);
  // R6
  esr_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> esr_o == $past(sr_i));
  // R7
  sr_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> sr_o[SM_BIT] && !sr_o[TEE_BIT] && !sr_o[IEE_BIT] &&
                   !sr_o[DME_BIT] && !sr_o[IME_BIT]);
  // R8
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> vec_pc_o[VEC_SHIFT-1:0] == '0 && vec_pc_o != '0);
  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cause_err_o |-> !redirect_o && !tlb_flush_o && $stable(epc_o) && $stable(sr_o));
  // R10
  flush_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> tlb_flush_o && xlate_off_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(exc_req_i) |-> !redirect_o && !cause_err_o && !tlb_flush_o);

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req_i = 1'b0;
  logic [3:0]  exc_cause_i = '0;
  logic [31:0] pc_cur_i = '0, pc_next_i = '0, pc_branch_i = '0, sr_i = '0;
  logic        ds_flag_i = 1'b0;
  logic        redirect_o, ds_clr_o, tlb_flush_o, xlate_off_o, cause_err_o;
  logic [31:0] vec_pc_o, epc_o, esr_o, sr_o;

  exc_entry_ctrl i_exc_entry_ctrl (.*);

  always #5 clk = ~clk;

  typedef struct {
    bit          legal;
    bit          ds;
    logic [31:0] epc, esr, sr, vec;
    string       rq;
  } item_t;

  item_t q[$];
  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] m_epc = '0, m_esr = '0, m_sr = '0, m_vec = '0;
  bit m_xl = 0;

  task automatic chk(string rq, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic drive(int cause, bit ds, logic [31:0] pcc, logic [31:0] pcn,
                       logic [31:0] pcb, logic [31:0] sr);
    item_t it;
    bit resume;
    @(negedge clk);
    exc_req_i = 1'b1; exc_cause_i = 4'(cause); ds_flag_i = ds;
    pc_cur_i = pcc; pc_next_i = pcn; pc_branch_i = pcb; sr_i = sr;
    resume = (cause == 5) || (cause == 8) || (cause == 12) || (cause == 13);
    it.legal = (cause >= 1) && (cause <= 14);
    it.ds = ds;
    if (!it.legal) it.rq = "R9";
    else if (ds) it.rq = "R4";
    else it.rq = resume ? "R2" : "R3";
    if (ds) it.epc = resume ? pcb : pcc - 32'd4;
    else    it.epc = resume ? pcn : pcc;
    it.esr = sr;
    it.sr = sr;
    it.sr[0] = 1'b1; it.sr[1] = 1'b0; it.sr[2] = 1'b0; it.sr[5] = 1'b0; it.sr[6] = 1'b0;
    if (ds) it.sr[13] = 1'b1;
    it.vec = 32'(cause) * 32'd256;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      exc_req_i = 1'b0;
      sr_i = $urandom; pc_cur_i = $urandom;
    end
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (q.size() > 0) begin
          it = q.pop_front();
          if (it.legal) begin
            m_epc = it.epc; m_esr = it.esr; m_sr = it.sr; m_vec = it.vec; m_xl = 1;
          end
          chk(it.rq, "epc", epc_o, m_epc);
          chk("R6", "esr", esr_o, m_esr);
          chk(it.ds ? "R5" : "R7", "sr", sr_o, m_sr);
          chk("R8", "redirect", 32'(redirect_o), 32'(it.legal));
          chk("R8", "vec", vec_pc_o, m_vec);
          chk("R5", "ds_clr", 32'(ds_clr_o), 32'(it.legal && it.ds));
          chk("R10", "flush", 32'(tlb_flush_o), 32'(it.legal));
          chk("R10", "xlate_off", 32'(xlate_off_o), 32'(m_xl));
          chk("R9", "cause_err", 32'(cause_err_o), 32'(!it.legal));
        end else begin
          chk("R11", "strobes", {28'd0, redirect_o, tlb_flush_o, ds_clr_o, cause_err_o}, 32'd0);
          chk("R11", "epc", epc_o, m_epc);
          chk("R11", "esr", esr_o, m_esr);
          chk("R11", "sr", sr_o, m_sr);
          chk("R11", "vec", vec_pc_o, m_vec);
          chk("R11", "xlate_off", 32'(xlate_off_o), 32'(m_xl));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : stim
    exc_req_i = 1'b1; exc_cause_i = 4'd3; sr_i = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    #2;
    // R1 outputs zero during reset even with a request present
    chk("R1", "held", epc_o | esr_o | sr_o | vec_pc_o, 32'd0);
    chk("R1", "strobes", {27'd0, redirect_o, tlb_flush_o, ds_clr_o, cause_err_o, xlate_off_o}, 32'd0);
    @(negedge clk);
    exc_req_i = 1'b0;
    rst_n = 1'b1;
    idle(2);
    // R2 R3 R4 R5 R6 R7 R8 R10: all causes, both delay-slot states
    for (int c = 1; c < 15; c++) begin
      for (int d = 0; d < 2; d++) begin
        drive(c, d[0], 32'h1000_0000 + 32'(c * 64), 32'h1000_0004 + 32'(c * 64),
              32'h2000_0000 + 32'(c * 16), $urandom);
        idle(1 + d);
      end
    end
    // R7 all-ones and all-zero status words
    drive(8, 1'b0, 32'h40, 32'h44, 32'h80, 32'hFFFF_FFFF); idle(1);
    drive(2, 1'b1, 32'h40, 32'h44, 32'h80, 32'h0000_0000); idle(1);
    drive(2, 1'b0, 32'h40, 32'h44, 32'h80, 32'h0000_2000); idle(1);
    // R9 illegal causes, standalone and right after an entry
    drive(0, 1'b0, 32'h500, 32'h504, 32'h600, 32'hABCD_1234); idle(2);
    drive(15, 1'b1, 32'h500, 32'h504, 32'h600, 32'h1234_ABCD); idle(2);
    drive(12, 1'b0, 32'h700, 32'h704, 32'h800, 32'h5555_AAAA);
    drive(0, 1'b1, 32'h900, 32'h904, 32'hA00, 32'hAAAA_5555); idle(2);
    // R8 R10 back-to-back legal entries
    drive(5, 1'b1, 32'hC00, 32'hC04, 32'hD00, 32'h0000_0077);
    drive(9, 1'b0, 32'hE00, 32'hE04, 32'hF00, 32'h0000_2066);
    drive(14, 1'b1, 32'h1100, 32'h1104, 32'h1200, 32'hFFFF_DFFF);
    idle(4);
    // R4 pc_cur - 4 wrapping below zero
    drive(1, 1'b1, 32'h0000_0000, 32'h4, 32'h8, 32'h0); idle(3);
    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule